// File: doc/BRIEF.md
# Two-Level Page Translator with Lookaside Cache

This block turns 32-bit virtual addresses into physical addresses for a 4 KB page size. Every request is first compared against a small fully associative lookaside cache of recent translations. All of its entries are compared at once. A hit returns the physical address in the next cycle and makes no memory access.

On a miss, a hardware walker reads the page tables through a simple memory port. It makes at most two reads. The first read fetches the outer-level entry from the table located by the base input. The second read fetches the inner-level entry from the table page that the first read named. A valid result is written into the cache and returned.

The block raises a page fault in three cases: an outer index beyond the table length input, an invalid outer entry, or an invalid inner entry. A fault returns the faulting virtual address and changes nothing in the cache. While a walk is in progress the block accepts no new request. A flush input empties the cache in one cycle.

Top module: `xlt_translator`

## Requirements
- R1: A virtual address splits into outer index = bits [31:22], inner index = bits [21:12] and page offset = bits [11:0]. A successful response carries paddr = {frame[19:0], offset}, and the offset is passed through unchanged.
- R2: A request that hits in the cache is answered one cycle after acceptance, with resp_fault low and no memory read. A hit keeps returning the cached frame even if the tables in memory are changed afterwards.
- R3: On a miss, the first read is at ptbr + 4*outer_index. If that outer entry is valid, the second read is at {outer_entry[31:12], inner_index, 2'b00}. A table entry holds its frame in bits [31:12] and its valid flag in bit 0.
- R4: A miss whose outer index is greater than or equal to tbl_len is answered one cycle after acceptance with resp_fault high, and no memory read is made.
- R5: An outer entry with bit 0 clear ends the walk after one read with a fault. An inner entry with bit 0 clear produces a fault after two reads.
- R6: Every fault response carries resp_vaddr equal to the request address and resp_paddr equal to zero. A faulting page is not cached, so a repeat of it walks again.
- R7: A successful walk installs the translation, so a later request to the same page hits.
- R8: The cache holds 8 translations and replaces them in round-robin order. The ninth distinct install evicts the first one installed, and the pointer is not moved by a flush.
- R9: One cycle with flush high invalidates every cached translation, so the next request to any page walks.
- R10: While a walk is in progress, req_ready is low. mem_req stays high with mem_addr stable until mem_ack is seen.
- R11: After reset, req_ready is high and resp_valid and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| ptbr | input | 32 | Physical base address of the outer table |
| tbl_len | input | 11 | Number of legal outer-table entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Response is a page fault |
| resp_paddr | output | 32 | Translated physical address (zero on fault) |
| resp_vaddr | output | 32 | Virtual address of the request answered |
| mem_req | output | 1 | Table read request, held until acknowledged |
| mem_addr | output | 32 | Table read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Table entry read |

## Verification
Some behaviours are checked by assertions on every cycle:
- a hit or an out-of-range miss answers in the next cycle with no memory request;
- req_ready is low whenever a read is outstanding;
- the read address holds until it is acknowledged;
- at most one cache entry matches;
- a flush leaves no valid entry;
- a faulting walk leaves the valid bits untouched.

Other behaviours can only be shown by the bench scenarios. These are the exact read addresses of each walk, the frame that comes back, round-robin eviction of the oldest entry, stale hits after the tables change, and the moving length boundary.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int PTE_W   = 32;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int LEN_W   = IDX_W + 1;

  typedef enum logic [1:0] {WK_IDLE, WK_OUTER, WK_INNER} walk_state_e;

  function automatic logic [IDX_W-1:0] outer_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] inner_index(input logic [VA_W-1:0] va);
    return va[OFF_W+IDX_W-1 -: IDX_W];
  endfunction

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic pte_valid(input logic [PTE_W-1:0] pte);
    return pte[0];
  endfunction

  function automatic logic [FRAME_W-1:0] pte_frame(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1 -: FRAME_W];
  endfunction

  function automatic logic [PA_W-1:0] outer_entry_addr(input logic [PA_W-1:0] base,
                                                       input logic [IDX_W-1:0] idx);
    return base + PA_W'({idx, 2'b00});
  endfunction

  function automatic logic [PA_W-1:0] inner_entry_addr(input logic [PTE_W-1:0] pte,
                                                       input logic [IDX_W-1:0] idx);
    return {pte_frame(pte), {OFF_W{1'b0}}} | PA_W'({idx, 2'b00});
  endfunction

  function automatic logic [PA_W-1:0] make_pa(input logic [FRAME_W-1:0] frame,
                                              input logic [VA_W-1:0] va);
    return {frame, va[OFF_W-1:0]};
  endfunction

  function automatic logic beyond_len(input logic [IDX_W-1:0] idx,
                                      input logic [LEN_W-1:0] len);
    return {1'b0, idx} >= len;
  endfunction
endpackage

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lookup_vpn,
  output logic               hit,
  output logic [FRAME_W-1:0] hit_frame,
  input  logic               install,
  input  logic [VPN_W-1:0]   install_vpn,
  input  logic [FRAME_W-1:0] install_frame,
  output logic [ENTRIES-1:0] valid_vec
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   victim_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[e] <= 1'b0;
        tag_q[e]     <= '0;
        frame_q[e]   <= '0;
      end else if (flush) begin
        valid_vec[e] <= 1'b0;
      end else if (install && victim_q == PTR_W'(e)) begin
        valid_vec[e] <= 1'b1;
        tag_q[e]     <= install_vpn;
        frame_q[e]   <= install_frame;
      end
    end
    assign hit_vec[e] = valid_vec[e] && (tag_q[e] == lookup_vpn);
  end

  always_comb begin
    hit_frame = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_vec[e]) hit_frame = hit_frame | frame_q[e];
    end
  end
  assign hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) victim_q <= '0;
    else if (install && !flush)
      victim_q <= (victim_q == PTR_W'(ENTRIES-1)) ? '0 : victim_q + 1'b1;
  end

  // R8: a page can be cached in at most one entry
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9: one flush cycle empties the cache
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
endmodule

// File: rtl/xlt_walker.sv
module xlt_walker
  import xlt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VA_W-1:0]    start_vaddr,
  input  logic [PA_W-1:0]    ptbr,
  output logic               busy,
  output logic               mem_req,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_ack,
  input  logic [PTE_W-1:0]   mem_rdata,
  output logic               done,
  output logic               done_fault,
  output logic [FRAME_W-1:0] done_frame
);
  walk_state_e     state_q;
  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] addr_q;
  logic            outer_ack, inner_ack;

  assign outer_ack = (state_q == WK_OUTER) && mem_ack;
  assign inner_ack = (state_q == WK_INNER) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (start) begin
          va_q    <= start_vaddr;
          addr_q  <= outer_entry_addr(ptbr, outer_index(start_vaddr));
          state_q <= WK_OUTER;
        end
        WK_OUTER: if (mem_ack) begin
          if (pte_valid(mem_rdata)) begin
            addr_q  <= inner_entry_addr(mem_rdata, inner_index(va_q));
            state_q <= WK_INNER;
          end else begin
            state_q <= WK_IDLE;
          end
        end
        WK_INNER: if (mem_ack) state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign mem_req    = (state_q != WK_IDLE);
  assign mem_addr   = addr_q;
  assign busy       = mem_req;
  assign done       = (outer_ack && !pte_valid(mem_rdata)) || inner_ack;
  assign done_fault = outer_ack || !pte_valid(mem_rdata);
  assign done_frame = pte_frame(mem_rdata);

  // R10: an unacknowledged read keeps its request and address
  a_r10_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R5: an invalid outer entry finishes the walk without a second read
  a_r5_outer_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (outer_ack && !pte_valid(mem_rdata)) |=> !mem_req);
endmodule

// File: rtl/xlt_translator.sv
module xlt_translator
  import xlt_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PA_W-1:0]   ptbr,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [PA_W-1:0]   resp_paddr,
  output logic [VA_W-1:0]   resp_vaddr,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [PTE_W-1:0]  mem_rdata
);
  logic                   accept, walk_busy;
  logic                   tlb_hit;
  logic [FRAME_W-1:0]     tlb_frame;
  logic [TLB_ENTRIES-1:0] tlb_valid;
  logic                   hit_ev, range_ev, walk_start;
  logic                   walk_done, walk_fault, install_ev;
  logic [FRAME_W-1:0]     walk_frame;

  assign req_ready  = !walk_busy;
  assign accept     = req_valid && req_ready;
  assign hit_ev     = accept && tlb_hit;
  assign range_ev   = accept && !tlb_hit && beyond_len(outer_index(req_vaddr), tbl_len);
  assign walk_start = accept && !tlb_hit && !range_ev;
  assign install_ev = walk_done && !walk_fault;

  xlt_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .lookup_vpn    (vpn_of(req_vaddr)),
    .hit           (tlb_hit),
    .hit_frame     (tlb_frame),
    .install       (install_ev),
    .install_vpn   (vpn_of(resp_vaddr)),
    .install_frame (walk_frame),
    .valid_vec     (tlb_valid)
  );

  xlt_walker u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (walk_start),
    .start_vaddr (req_vaddr),
    .ptbr        (ptbr),
    .busy        (walk_busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .done        (walk_done),
    .done_fault  (walk_fault),
    .done_frame  (walk_frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
      resp_vaddr <= '0;
    end else begin
      resp_valid <= hit_ev || range_ev || walk_done;
      if (accept) resp_vaddr <= req_vaddr;
      if (hit_ev) begin
        resp_fault <= 1'b0;
        resp_paddr <= make_pa(tlb_frame, req_vaddr);
      end else if (range_ev) begin
        resp_fault <= 1'b1;
        resp_paddr <= '0;
      end else if (walk_done) begin
        resp_fault <= walk_fault;
        resp_paddr <= walk_fault ? '0 : make_pa(walk_frame, resp_vaddr);
      end
    end
  end

  // R2: a hit answers next cycle without touching memory
  a_r2_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> (resp_valid && !resp_fault && !mem_req));

  // R4: an out-of-range index faults next cycle with no read
  a_r4_range_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    range_ev |=> (resp_valid && resp_fault && !mem_req));

  // R10: no request is taken while a read is outstanding
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R6: a faulting walk leaves the cache valid bits alone
  a_r6_no_install: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault && !flush) |=> $stable(tlb_valid));
endmodule

// File: tb/test_xlt_translator.sv
module test_xlt_translator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] ptbr = 32'h0001_0000;
  logic [10:0] tbl_len = 11'd4;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_paddr, resp_vaddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit expect_resp = 1'b0;

  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] read_log [$];

  logic [19:0] m_vpn [8];
  logic [19:0] m_frm [8];
  bit          m_v   [8];
  int          m_rr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlt_translator i_xlt_translator (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ptbr(ptbr), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .resp_vaddr(resp_vaddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_model.exists(a) ? mem_model[a] : 32'h0;
  endfunction

  function automatic logic [31:0] va(input int o, input int i, input int off);
    return {o[9:0], i[9:0], off[11:0]};
  endfunction

  // Memory responder: acknowledges one cycle after each request appears
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= rd(mem_addr);
      read_log.push_back(mem_addr);
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-clock monitor
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (resp_valid && !expect_resp) begin
        errors++; checks++;
        $display("FAIL R2: unexpected response actual %0h expected 0", resp_valid);
      end
      if (mem_req && req_ready) begin
        errors++; checks++;
        $display("FAIL R10: ready during walk actual %0h expected 0", req_ready);
      end
    end
  end

  task automatic do_xlate(input logic [31:0] v, input string tag);
    logic [19:0] vpn = v[31:12];
    bit exp_fault = 1'b0;
    bit exp_hit = 1'b0;
    logic [19:0] exp_frame = '0;
    logic [31:0] exp_reads [$];
    logic [31:0] opte, ipte, oa, ia;
    int lat = 0;
    for (int e = 0; e < 8; e++)
      if (m_v[e] && m_vpn[e] == vpn) begin exp_hit = 1'b1; exp_frame = m_frm[e]; end
    if (!exp_hit) begin
      if ({1'b0, v[31:22]} >= tbl_len) exp_fault = 1'b1;
      else begin
        oa = ptbr + 32'(v[31:22]) * 4;
        exp_reads.push_back(oa);
        opte = rd(oa);
        if (!opte[0]) exp_fault = 1'b1;
        else begin
          ia = {opte[31:12], 12'h0} + 32'(v[21:12]) * 4;
          exp_reads.push_back(ia);
          ipte = rd(ia);
          if (!ipte[0]) exp_fault = 1'b1;
          else begin
            exp_frame = ipte[31:12];
            m_vpn[m_rr] = vpn; m_frm[m_rr] = exp_frame; m_v[m_rr] = 1'b1;
            m_rr = (m_rr + 1) % 8;
          end
        end
      end
    end
    read_log.delete();
    chk(req_ready === 1'b1, {tag, " R10 ready before request"}, req_ready, 1);
    expect_resp = 1'b1;
    req_valid = 1'b1; req_vaddr = v;
    @(posedge clk); #1 req_valid = 1'b0;
    do begin
      @(negedge clk); lat++;
      if (lat == 1 && exp_reads.size() > 0)
        chk(!req_ready && mem_req, {tag, " R10 stalled while walking"}, req_ready, 0);
    end while (!resp_valid && lat < 30);
    chk(resp_valid === 1'b1, {tag, " response seen"}, resp_valid, 1);
    if (exp_hit || exp_reads.size() == 0)
      chk(lat == 1, {tag, " R2/R4 one-cycle latency"}, lat, 1);
    chk(resp_fault === exp_fault, {tag, " fault flag"}, resp_fault, exp_fault);
    chk(resp_vaddr === v, {tag, " R6 vaddr returned"}, resp_vaddr, v);
    chk(resp_paddr === (exp_fault ? 32'h0 : {exp_frame, v[11:0]}),
        {tag, " R1 physical address"}, resp_paddr, exp_fault ? 32'h0 : {exp_frame, v[11:0]});
    chk(read_log.size() == exp_reads.size(), {tag, " R3 read count"}, read_log.size(), exp_reads.size());
    for (int k = 0; k < exp_reads.size() && k < read_log.size(); k++)
      chk(read_log[k] === exp_reads[k], {tag, " R3 read address"}, read_log[k], exp_reads[k]);
    @(negedge clk);
    expect_resp = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    for (int e = 0; e < 8; e++) m_v[e] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < 8; e++) m_v[e] = 1'b0;
    // Outer table at 0x10000: entry 1 invalid
    mem_model[32'h0001_0000] = 32'h0002_0001;
    mem_model[32'h0001_0004] = 32'h0000_0000;
    mem_model[32'h0001_0008] = 32'h0002_1001;
    mem_model[32'h0001_000C] = 32'h0002_2001;
    for (int k = 0; k < 16; k++)
      mem_model[32'h0002_0000 + k*4] = (k == 5) ? 32'h0 : {20'h00100 + 20'(k), 12'h001};
    for (int k = 0; k < 4; k++)
      mem_model[32'h0002_1000 + k*4] = {20'h00200 + 20'(k), 12'h001};
    mem_model[32'h0002_2000 + 7*4] = 32'hABCD_E001;

    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_req === 1'b0, "R11 reset state",
        {req_ready, resp_valid, mem_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    do_xlate(va(0, 0, 12'h123), "R7 first walk");
    do_xlate(va(0, 0, 12'hFFF), "R2 R7 repeat hits");
    do_xlate(va(1, 0, 12'h010), "R5 outer invalid");
    do_xlate(va(0, 5, 12'h020), "R5 inner invalid");
    do_xlate(va(0, 5, 12'h024), "R6 fault not cached");
    do_xlate(va(4, 0, 12'h000), "R4 index at length");
    do_xlate(va(1023, 3, 12'h000), "R4 top index");
    do_xlate(va(3, 7, 12'h456), "R1 split and concat");
    for (int k = 1; k <= 8; k++)
      if (k != 5) do_xlate(va(0, k, 12'h0AB), "R8 fill");
    do_xlate(va(0, 0, 12'h321), "R8 oldest evicted");
    do_xlate(va(3, 7, 12'h001), "R8 second oldest evicted");
    do_xlate(va(0, 2, 12'h002), "R8 survivor hits");
    mem_model[32'h0002_0008] = 32'h0077_7001;
    do_xlate(va(0, 2, 12'h003), "R2 stale hit");
    do_flush();
    do_xlate(va(0, 2, 12'h004), "R9 walk after flush");
    do_xlate(va(0, 8, 12'h005), "R9 second page walks");
    tbl_len = 11'd2;
    do_xlate(va(2, 1, 12'h006), "R4 lowered length");
    tbl_len = 11'd3;
    do_xlate(va(2, 1, 12'h007), "R4 index below length");
    do_xlate(va(2, 3, 12'h008), "R3 other inner table");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule